// File: doc/BRIEF.md
# Full-Period 8-Bit Sequence Generator

This block produces a pseudo-random sequence of 8-bit words. It uses a shift register whose entry bit is the XOR of four stages. A mode input picks between two behaviours. The plain behaviour is the classic maximal-length cycle of 255 non-zero words, in which the all-zero word cannot be left. The full behaviour adds a correction term into the feedback: the NOR of the seven bits that stay in the register. That term splices the all-zero word into the cycle, so the period becomes 256 and no state can trap the generator.

The host can load a seed word at any time, and the load beats a step request in the same cycle. It can also advance the generator one position per enabled clock, or hold it. Both the whole register and the bit that leaves it are visible at the outputs. The mode input is meant to be changed only while the generator is not stepping.

Top module: `seqgen_top`

## Requirements
- R1: While `rst_n` is low the register holds 0x01, so `state_o` reads 0x01 and `bit_o` reads 0.
- R2: A clock edge with `load_i` high writes `seed_i` into the register, whatever the value of `step_i`.
- R3: A clock edge with both `load_i` and `step_i` low leaves `state_o` unchanged.
- R4: A clock edge with `step_i` high and `load_i` low moves each bit one place up (`state_o[k]` takes the old `state_o[k-1]`) and puts the feedback bit into `state_o[0]`. `bit_o` always equals `state_o[7]`.
- R5: In plain mode (`full_mode_i` = 0) the feedback bit is the XOR of old bits 7, 5, 4 and 2. Starting from 0x01, the generator returns to 0x01 after exactly 255 steps and visits no word twice on the way.
- R6: In plain mode a register holding 0x00 stays at 0x00 on every step.
- R7: In full mode (`full_mode_i` = 1), starting from 0x01, the generator visits all 256 words exactly once and returns to 0x01 after 256 steps.
- R8: In full mode, 0x80 steps to 0x00 and 0x00 steps to 0x01. Every other word steps to the same successor as in plain mode.
- R9: Over one period `bit_o` shows 128 ones and 127 zeros in plain mode, and 128 ones and 128 zeros in full mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| load_i | input | 1 | Seed load strobe; has priority over stepping |
| seed_i | input | 8 | Word written on a load |
| step_i | input | 1 | Advance the generator by one position |
| full_mode_i | input | 1 | 0 = 255-word cycle, 1 = 256-word cycle |
| state_o | output | 8 | Current register contents |
| bit_o | output | 1 | Serial output, the most significant stage |

## Verification
A wrong feedback tap or a broken correction term shows on `state_o[0]` on the very next step after the word that exercises it. A fault that only touches the 0x80/0x00 splice, though, can stay hidden for up to a full period of free running. For that reason every one of the 256 words is loaded in both modes and stepped once. Each successor is compared against an arithmetic model of the requirements. Full-period runs in both modes then confirm the period, the absence of repeats and the balance of ones and zeros on `bit_o`.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
  localparam int unsigned SEQ_W = 8;
  // Stages tapped by the feedback XOR, zero-based bit positions 7, 5, 4, 2
  localparam logic [SEQ_W-1:0] SEQ_TAPS = 8'b1011_0100;
  localparam logic [SEQ_W-1:0] SEQ_RESET = 8'h01;

  typedef enum logic {
    CYC_PLAIN = 1'b0,
    CYC_FULL  = 1'b1
  } cyc_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } reg_act_e;
endpackage

// File: rtl/seqgen_fb.sv
module seqgen_fb
  import seqgen_pkg::*;
#(
  parameter int unsigned     W    = SEQ_W,
  parameter logic [W-1:0]    TAPS = SEQ_TAPS
) (
  input  logic [W-1:0] cur_i,
  input  cyc_mode_e    mode_i,
  output logic         fb_o
);
  localparam int unsigned KEEP_W = W - 1;

  logic [W-1:0] tap_terms;
  logic         lin_fb;
  logic         keep_zero;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      if (TAPS[gi]) begin : g_on
        assign tap_terms[gi] = cur_i[gi];
      end else begin : g_off
        assign tap_terms[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    lin_fb    = ^tap_terms;
    keep_zero = ~|cur_i[KEEP_W-1:0];
    fb_o      = lin_fb ^ ((mode_i == CYC_FULL) & keep_zero);
  end
endmodule

// File: rtl/seqgen_next.sv
module seqgen_next
  import seqgen_pkg::*;
#(
  parameter int unsigned W = SEQ_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] seed_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         fb_i,
  output logic [W-1:0] nxt_o,
  output logic         en_o
);
  reg_act_e act;

  always_comb begin
    if (load_i)      act = ACT_LOAD;
    else if (step_i) act = ACT_STEP;
    else             act = ACT_HOLD;
  end

  always_comb begin
    nxt_o = cur_i;
    en_o  = 1'b0;
    case (act)
      ACT_LOAD: begin
        nxt_o = seed_i;
        en_o  = 1'b1;
      end
      ACT_STEP: begin
        nxt_o = {cur_i[W-2:0], fb_i};
        en_o  = 1'b1;
      end
      default: begin
        nxt_o = cur_i;
        en_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/seqgen_reg.sv
module seqgen_reg
  import seqgen_pkg::*;
#(
  parameter int unsigned  W       = SEQ_W,
  parameter logic [W-1:0] RST_VAL = SEQ_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= RST_VAL;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
#(
  parameter int unsigned  W       = SEQ_W,
  parameter logic [W-1:0] TAPS    = SEQ_TAPS,
  parameter logic [W-1:0] RST_VAL = SEQ_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  input  logic         full_mode_i,
  output logic [W-1:0] state_o,
  output logic         bit_o
);
  logic [W-1:0] cur_q;
  logic [W-1:0] nxt_d;
  logic         fb;
  logic         reg_en;
  cyc_mode_e    mode;

  assign mode = cyc_mode_e'(full_mode_i);

  seqgen_fb #(.W(W), .TAPS(TAPS)) fb_i (
    .cur_i  (cur_q),
    .mode_i (mode),
    .fb_o   (fb)
  );

  seqgen_next #(.W(W)) next_i (
    .cur_i  (cur_q),
    .seed_i (seed_i),
    .load_i (load_i),
    .step_i (step_i),
    .fb_i   (fb),
    .nxt_o  (nxt_d),
    .en_o   (reg_en)
  );

  seqgen_reg #(.W(W), .RST_VAL(RST_VAL)) reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (reg_en),
    .d_i   (nxt_d),
    .q_o   (cur_q)
  );

  assign state_o = cur_q;
  assign bit_o   = cur_q[W-1];
endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic [W-1:0] seed_i,
  input logic         step_i,
  input logic         full_mode_i,
  input logic [W-1:0] state_o,
  input logic         bit_o
);
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> state_o == $past(seed_i)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(state_o)); // R3

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> state_o[W-1:1] == $past(state_o[W-2:0])); // R4

  AST_SERIAL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> bit_o == $past(state_o[W-2])); // R4

  AST_PLAIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !full_mode_i && state_o == '0) |=> state_o == '0); // R6

  AST_FULL_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && full_mode_i && state_o == TOP_ONLY) |=> state_o == '0); // R8

  AST_FULL_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && full_mode_i && state_o == '0) |=> state_o == ONE); // R8
endmodule

bind seqgen_top seqgen_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .seed_i      (seed_i),
  .step_i      (step_i),
  .full_mode_i (full_mode_i),
  .state_o     (state_o),
  .bit_o       (bit_o)
);

// File: tb/seqgen_top_tb_top.sv
`timescale 1ns/1ps
module seqgen_top_tb_top;
  logic       clk;
  logic       rst_n;
  logic       load_i;
  logic [7:0] seed_i;
  logic       step_i;
  logic       full_mode_i;
  logic [7:0] state_o;
  logic       bit_o;

  int checks;
  int fails;
  bit done;

  seqgen_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .seed_i      (seed_i),
    .step_i      (step_i),
    .full_mode_i (full_mode_i),
    .state_o     (state_o),
    .bit_o       (bit_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Successor word computed from R4, R5 and R8
  function automatic logic [7:0] succ(input logic [7:0] s, input logic full);
    logic f;
    f = s[7] ^ s[5] ^ s[4] ^ s[2];
    if (full && s[6:0] == 7'd0) f = ~f;
    return {s[6:0], f};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sweep(input logic full, input int period, input string rq);
    bit seen [256];
    int ones;
    int zeros;
    logic [7:0] exp;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    ones = 0;
    zeros = 0;
    load_i = 1'b1; seed_i = 8'h01; step_i = 1'b0; full_mode_i = full;
    @(negedge clk);
    load_i = 1'b0;
    chk(state_o == 8'h01, rq, state_o, 8'h01);
    step_i = 1'b1;
    for (int k = 0; k < period; k++) begin
      chk(!seen[state_o], rq, state_o, -1);
      seen[state_o] = 1'b1;
      if (bit_o) ones++; else zeros++;
      exp = succ(state_o, full);
      @(negedge clk);
      chk(state_o == exp, full ? "R8" : "R5", state_o, exp);
    end
    step_i = 1'b0;
    chk(state_o == 8'h01, rq, state_o, 8'h01);
    chk(ones == 128, "R9", ones, 128);
    chk(zeros == (full ? 128 : 127), "R9", zeros, full ? 128 : 127);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; load_i = 1'b0; seed_i = 8'h00; step_i = 1'b0; full_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(state_o == 8'h01, "R1", state_o, 8'h01);
    chk(bit_o == 1'b0, "R1", bit_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 plain period, R7 full period, both with R9 balance
    sweep(1'b0, 255, "R5");
    sweep(1'b1, 256, "R7");

    // Exhaustive single-step transitions in both modes (R2, R3, R4, R5, R8)
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        full_mode_i = m[0];
        load_i = 1'b1; seed_i = v[7:0]; step_i = 1'b1;
        @(negedge clk);
        chk(state_o == v[7:0], "R2", state_o, v);
        chk(bit_o == v[7], "R4", bit_o, v[7]);
        load_i = 1'b0;
        @(negedge clk);
        chk(state_o == succ(v[7:0], m[0]), m[0] ? "R8" : "R5", state_o, succ(v[7:0], m[0]));
        step_i = 1'b0;
        seed_i = ~seed_i;
        @(negedge clk);
        chk(state_o == succ(v[7:0], m[0]), "R3", state_o, succ(v[7:0], m[0]));
      end
    end

    // R6: zero is a trap in plain mode
    full_mode_i = 1'b0; load_i = 1'b1; seed_i = 8'h00;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(state_o == 8'h00, "R6", state_o, 0);
    end
    step_i = 1'b0;

    // R8 explicit splice points
    full_mode_i = 1'b1; load_i = 1'b1; seed_i = 8'h80;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b1;
    @(negedge clk);
    chk(state_o == 8'h00, "R8", state_o, 0);
    @(negedge clk);
    chk(state_o == 8'h01, "R8", state_o, 1);
    step_i = 1'b0;

    // R1 reset mid-run
    load_i = 1'b1; seed_i = 8'hC3;
    @(negedge clk);
    load_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(state_o == 8'h01, "R1", state_o, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule